// File: doc/BRIEF.md
# CAN Nominal Bit Timer with Sample Voting

This block turns a fast system clock into the bit timing a CAN receiver needs. A programmable prescaler makes a time-quantum tick. A segment sequencer then walks every nominal bit through a one-quantum synchronization segment, a propagation segment, a first phase segment and a second phase segment. At the end of the first phase segment the receive line is read. Either one sample is used, or three samples half a quantum apart are combined by a two-of-three vote. The result is presented with a one-clock valid strobe.

A one-clock bit-start strobe marks the first clock of each synchronization segment, so a transmitter can align its next bit to it. A hard-sync request restarts the current bit at once. Configuration is captured only when a bit begins, so changing the inputs never disturbs a bit in progress. A flag reports when the captured configuration gives a bit shorter than six quanta.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts 2 x (cfg_brp + 1) clock cycles, with cfg_brp ranging 0 to 63. A bit lasts its total quantum count times that, and so consecutive bit_start pulses are that many cycles apart.
- R2: cfg_prop and cfg_ph1 each encode a length of code + 1 quanta (1 to 8). The sample point lies at the end of the first phase segment, so rx_valid rises 2 x (cfg_brp + 1) x (1 + prop length + phase-1 length) cycles after bit_start rises.
- R3: cfg_ph2 encodes a length of code + 1 quanta. A programmed length below 2 is used as 2.
- R4: With cfg_ph2_auto = 1, the second phase segment lasts the larger of the phase-1 length and 2 quanta, and cfg_ph2 is ignored.
- R5: rx_valid is high for exactly one clock per bit. With cfg_triple = 0, rx_bit equals the receive line as captured at the sample-point clock edge.
- R6: With cfg_triple = 1, rx_bit is the majority of three captures: at the sample-point edge, and 1 and 2 half-quanta (cfg_brp + 1 cycles each) before it.
- R7: bit_start is high for exactly one clock, the first clock of each synchronization segment. It is never high in the same clock as rx_valid.
- R8: cfg_bad is 1 while the captured configuration gives fewer than 6 quanta per bit, and 0 otherwise.
- R9: A hard_sync high at a clock edge makes bit_start high in the next clock. The bit restarts from its synchronization segment with a fresh prescaler, and no sample is taken at that edge.
- R10: Configuration inputs are captured only at the edge where a bit begins. Changes made during a bit take effect from the next bit.
- R11: While reset is held, rx_valid and bit_start are 0. After rst_n rises, the first bit_start appears in the third clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_brp | input | 6 | Prescaler code; quantum = 2 x (code + 1) clocks |
| cfg_prop | input | 3 | Propagation segment length minus one |
| cfg_ph1 | input | 3 | First phase segment length minus one |
| cfg_ph2 | input | 3 | Second phase segment length minus one (floor 2 quanta) |
| cfg_ph2_auto | input | 1 | 1: second phase = max(first phase, 2 quanta) |
| cfg_triple | input | 1 | 1: majority of three samples |
| rx_line | input | 1 | Receive bus level |
| hard_sync | input | 1 | Restart the bit at its synchronization segment |
| rx_bit | output | 1 | Sampled bit value |
| rx_valid | output | 1 | One-clock strobe, rx_bit is new |
| bit_start | output | 1 | One-clock strobe at the start of each bit |
| cfg_bad | output | 1 | Captured configuration is under 6 quanta |

## Verification
Each result has a fixed due cycle. The bench counts falling edges from the falling edge where bit_start is seen, and reads each output only at that count. rx_valid is due 2(brp+1)(1+prop+ph1) edges later and the next bit_start 2(brp+1)(total) edges later. bit_start follows a hard sync by one edge and follows reset release by three. For triple sampling, the receive line is changed at chosen counts so that the three capture edges, at counts 31, 27 and 23 before the strobe at 32, see known levels. Configuration changes are applied at a bit_start edge and checked against the bit already running and the following one.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [BRP_W-1:0] brp,
  output logic             half_tick,
  output logic             tq_tick
);

  logic [BRP_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;

  assign half_tick = (cnt_q == brp);
  assign tq_tick   = half_tick & phase_q;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (restart) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (half_tick) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
    end else begin
      cnt_d   = cnt_q + BRP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/can_bt_sequencer.sv
module can_bt_sequencer
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             restart_req,
  input  logic [SEG_W-1:0] prop_m1,
  input  logic [SEG_W-1:0] ph1_m1,
  input  logic [SEG_W-1:0] ph2_m1,
  output logic             enter_sync,
  output logic             sample_pt
);

  seg_e             seg_q, seg_d;
  logic [SEG_W-1:0] qcnt_q, qcnt_d;
  logic [SEG_W-1:0] cur_m1;
  logic             seg_last;

  always_comb begin
    unique case (seg_q)
      SEG_SYNC: cur_m1 = '0;
      SEG_PROP: cur_m1 = prop_m1;
      SEG_PH1:  cur_m1 = ph1_m1;
      default:  cur_m1 = ph2_m1;
    endcase
  end

  assign seg_last   = (qcnt_q == cur_m1);
  assign enter_sync = restart_req | (tq_tick & seg_last & (seg_q == SEG_PH2));
  assign sample_pt  = tq_tick & seg_last & (seg_q == SEG_PH1) & ~restart_req;

  always_comb begin
    seg_d  = seg_q;
    qcnt_d = qcnt_q;
    if (restart_req) begin
      seg_d  = SEG_SYNC;
      qcnt_d = '0;
    end else if (tq_tick) begin
      if (seg_last) begin
        qcnt_d = '0;
        unique case (seg_q)
          SEG_SYNC: seg_d = SEG_PROP;
          SEG_PROP: seg_d = SEG_PH1;
          SEG_PH1:  seg_d = SEG_PH2;
          default:  seg_d = SEG_SYNC;
        endcase
      end else begin
        qcnt_d = qcnt_q + SEG_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
    end else begin
      seg_q  <= seg_d;
      qcnt_q <= qcnt_d;
    end
  end

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
#(
  parameter int HIST_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  input  logic sample_pt,
  input  logic triple,
  input  logic rx_line,
  output logic rx_bit,
  output logic rx_valid
);

  logic [HIST_N-1:0] hist_q, hist_d;
  logic              bit_q, bit_d;
  logic              valid_q;
  logic              vote;

  assign vote = triple ? maj3(hist_q[1], hist_q[0], rx_line) : rx_line;

  always_comb begin
    hist_d = hist_q;
    if (half_tick) hist_d = {hist_q[HIST_N-2:0], rx_line};
    bit_d = bit_q;
    if (sample_pt) bit_d = vote;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      bit_q   <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      bit_q   <= bit_d;
      valid_q <= sample_pt;
    end
  end

  assign rx_bit   = bit_q;
  assign rx_valid = valid_q;

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W      = 6,
  parameter int SEG_W      = 3,
  parameter int MIN_BIT_TQ = 6,
  parameter int PH2_MIN_TQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic             cfg_ph2_auto,
  input  logic             cfg_triple,
  input  logic             rx_line,
  input  logic             hard_sync,
  output logic             rx_bit,
  output logic             rx_valid,
  output logic             bit_start,
  output logic             cfg_bad
);

  localparam int TOT_W      = SEG_W + 2;
  localparam int PH2_MIN_M1 = PH2_MIN_TQ - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // first-bit start after reset
  logic fresh_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) fresh_q <= 1'b1;
    else            fresh_q <= 1'b0;
  end

  logic restart_req, enter_sync, sample_pt, half_tick, tq_tick;
  assign restart_req = hard_sync | fresh_q;

  // configuration capture at the bit boundary
  logic [BRP_W-1:0] brp_q, brp_d;
  logic [SEG_W-1:0] prop_q, prop_d, ph1_q, ph1_d, ph2_q, ph2_d;
  logic             triple_q, triple_d, bad_q, bad_d, start_q;
  logic [SEG_W-1:0] ph2_base;
  logic [TOT_W-1:0] total_tq;
  logic             cfg_load;

  assign cfg_load = enter_sync;
  assign ph2_base = cfg_ph2_auto ? cfg_ph1 : cfg_ph2;
  assign total_tq = TOT_W'(cfg_prop) + TOT_W'(cfg_ph1) + TOT_W'(ph2_d) + TOT_W'(4);

  always_comb begin
    ph2_d    = (ph2_base < SEG_W'(PH2_MIN_M1)) ? SEG_W'(PH2_MIN_M1) : ph2_base;
    brp_d    = brp_q;
    prop_d   = prop_q;
    ph1_d    = ph1_q;
    triple_d = triple_q;
    bad_d    = bad_q;
    if (cfg_load) begin
      brp_d    = cfg_brp;
      prop_d   = cfg_prop;
      ph1_d    = cfg_ph1;
      triple_d = cfg_triple;
      bad_d    = (total_tq < TOT_W'(MIN_BIT_TQ));
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      brp_q    <= '0;
      prop_q   <= '0;
      ph1_q    <= '0;
      ph2_q    <= SEG_W'(PH2_MIN_M1);
      triple_q <= 1'b0;
      bad_q    <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      brp_q    <= brp_d;
      prop_q   <= prop_d;
      ph1_q    <= ph1_d;
      if (cfg_load) ph2_q <= ph2_d;
      triple_q <= triple_d;
      bad_q    <= bad_d;
      start_q  <= enter_sync;
    end
  end

  can_bt_prescaler #(.BRP_W(BRP_W)) i_presc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart   (enter_sync),
    .brp       (brp_q),
    .half_tick (half_tick),
    .tq_tick   (tq_tick)
  );

  can_bt_sequencer #(.SEG_W(SEG_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tq_tick     (tq_tick),
    .restart_req (restart_req),
    .prop_m1     (prop_q),
    .ph1_m1      (ph1_q),
    .ph2_m1      (ph2_q),
    .enter_sync  (enter_sync),
    .sample_pt   (sample_pt)
  );

  can_bt_sampler #(.HIST_N(2)) i_samp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .half_tick (half_tick),
    .sample_pt (sample_pt),
    .triple    (triple_q),
    .rx_line   (rx_line),
    .rx_bit    (rx_bit),
    .rx_valid  (rx_valid)
  );

  assign bit_start = start_q;
  assign cfg_bad   = bad_q;

endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
  input logic clk,
  input logic rst_int_n,
  input logic hard_sync,
  input logic rx_valid,
  input logic bit_start,
  input logic cfg_bad
);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_valid |=> !rx_valid)
    else $error("rx_valid longer than one clock");

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bit_start && !hard_sync) |=> !bit_start)
    else $error("bit_start longer than one clock");

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bit_start && rx_valid))
    else $error("bit_start and rx_valid together");

  p_hsync_start_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    hard_sync |=> bit_start)
    else $error("hard sync did not restart the bit");

  p_hsync_nosample_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    hard_sync |=> !rx_valid)
    else $error("sample taken at hard sync");

  p_bad_held_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bit_start |-> $stable(cfg_bad))
    else $error("cfg_bad changed inside a bit");

endmodule

bind can_bit_timer can_bt_checker i_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .hard_sync (hard_sync),
  .rx_valid  (rx_valid),
  .bit_start (bit_start),
  .cfg_bad   (cfg_bad)
);

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] cfg_brp;
  logic [2:0] cfg_prop, cfg_ph1, cfg_ph2;
  logic       cfg_ph2_auto, cfg_triple, rx_line, hard_sync;
  logic       rx_bit, rx_valid, bit_start, cfg_bad;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_prop(cfg_prop),
    .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_ph2_auto(cfg_ph2_auto),
    .cfg_triple(cfg_triple), .rx_line(rx_line), .hard_sync(hard_sync),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .bit_start(bit_start), .cfg_bad(cfg_bad)
  );

  // {brp, prop code, ph1 code, ph2 code, auto, sample offset, period, bad}
  localparam logic [40:0] VEC [6] = '{
    {6'd0,  3'd1, 3'd2, 3'd1, 1'b0, 12'd12,  12'd16,  1'b0},  // 8 tq bit, 16 clocks
    {6'd1,  3'd0, 3'd0, 3'd0, 1'b0, 12'd12,  12'd20,  1'b1},  // ph2 floor, 5 tq
    {6'd2,  3'd2, 3'd3, 3'd7, 1'b1, 12'd48,  12'd72,  1'b0},  // auto ph2 = ph1
    {6'd0,  3'd7, 3'd7, 3'd7, 1'b0, 12'd34,  12'd50,  1'b0},  // 25 tq
    {6'd3,  3'd0, 3'd1, 3'd1, 1'b0, 12'd32,  12'd48,  1'b0},  // 6 tq edge
    {6'd63, 3'd0, 3'd0, 3'd0, 1'b1, 12'd384, 12'd640, 1'b1}   // max prescale, auto floor
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [40:0] v, input logic triple);
    cfg_brp      = v[40:35];
    cfg_prop     = v[34:32];
    cfg_ph1      = v[31:29];
    cfg_ph2      = v[28:26];
    cfg_ph2_auto = v[25];
    cfg_triple   = triple;
  endtask

  task automatic wait_start();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (bit_start) return;
    end
  endtask

  // called at a negedge where bit_start is high
  task automatic measure(output int off, output int per, output logic bitv);
    off = -1; per = -1; bitv = 1'bx;
    for (int n = 1; n < 5000; n++) begin
      @(negedge clk);
      if (rx_valid && off < 0) begin off = n; bitv = rx_bit; end
      if (bit_start) begin per = n; return; end
    end
  endtask

  // at bit_start negedge: rx low from negedge lo up to negedge 32, strobe at 32
  task automatic glitch(input int lo, input int exp, input string req);
    for (int n = 1; n <= 32; n++) begin
      @(negedge clk);
      if (n == 32) begin
        chk({req, " valid at sample point"}, int'(rx_valid), 1);
        chk({req, " voted bit"}, int'(rx_bit), exp);
      end
      rx_line = (n >= lo && n < 32) ? 1'b0 : 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int off, per, cnt;
    logic bitv;
    rst_n = 1'b0; hard_sync = 1'b0; rx_line = 1'b1;
    set_cfg(VEC[0], 1'b0);
    repeat (4) @(negedge clk);
    chk("R11 reset rx_valid", int'(rx_valid), 0);
    chk("R11 reset bit_start", int'(bit_start), 0);
    rst_n = 1'b1;
    cnt = 0;
    for (int n = 1; n < 20; n++) begin
      @(negedge clk);
      if (bit_start) begin cnt = n; break; end
    end
    chk("R11 first bit_start delay", cnt, 3);

    // table walk: R1 R2 R3 R4 R5 R8
    foreach (VEC[i]) begin
      set_cfg(VEC[i], 1'b0);
      rx_line = i[0];
      wait_start();
      chk("R8 cfg_bad", int'(cfg_bad), int'(VEC[i][0]));
      measure(off, per, bitv);
      chk("R2 sample point offset", off, int'(VEC[i][24:13]));
      chk("R1 R3 R4 bit period", per, int'(VEC[i][12:1]));
      chk("R5 single sample value", int'(bitv), i[0]);
    end

    // R10: config change mid-bit waits for the next bit
    set_cfg(VEC[0], 1'b0);
    wait_start();
    wait_start();
    set_cfg(VEC[2], 1'b0);
    measure(off, per, bitv);
    chk("R10 old offset kept", off, 12);
    chk("R10 old period kept", per, 16);
    measure(off, per, bitv);
    chk("R10 new period applied", per, 72);

    // R9: hard sync mid-bit
    set_cfg(VEC[0], 1'b0);
    wait_start();
    wait_start();
    repeat (5) @(negedge clk);
    hard_sync = 1'b1;
    @(negedge clk);
    hard_sync = 1'b0;
    chk("R9 bit_start after hard sync", int'(bit_start), 1);
    measure(off, per, bitv);
    chk("R9 restarted sample offset", off, 12);
    chk("R9 restarted period", per, 16);

    // R6 triple sampling, R5 single-sample contrast
    rx_line = 1'b1;
    set_cfg(VEC[4], 1'b1);
    wait_start();
    wait_start();
    glitch(30, 1, "R6 one low sample outvoted");
    wait_start();
    glitch(26, 0, "R6 two low samples win");
    set_cfg(VEC[4], 1'b0);
    wait_start();
    wait_start();
    glitch(30, 0, "R5 single sample follows line");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule